// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDR SDRAM device from power-on to normal operation. After a single start pulse it raises the clock enable and drives NOP for a programmable settling period. It then issues PRECHARGE ALL and eight AUTO REFRESH commands, and loads the mode register with CAS latency 3 and a burst length of one. Each command is followed by its own programmable wait. When the last wait has elapsed the block raises `init_done_o`. From that point it produces a one-cycle `refresh_req_o` pulse at a fixed interval for whatever logic owns the bus in normal mode.

All timing inputs are given in clock cycles. The block also computes the write-recovery time in cycles from the row timing inputs. That value is offered to the downstream controller.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_ni` is low and afterwards until a start, `cke_o` is 0, `cs_no` is 1, and `init_done_o` and `refresh_req_o` are 0. An asserted reset returns the block to this state from any point of the sequence.
- R2: A start pulse sampled in idle makes `cke_o` high from the next cycle. NOP ({cs,ras,cas,we} = 0111) is then driven for max(t_pwr,1) cycles, and after that PRECHARGE ALL is issued.
- R3: PRECHARGE ALL lasts one cycle with {cs,ras,cas,we} = 0010 and the address bus equal to 0x400 (bit 10 high only).
- R4: Exactly eight AUTO REFRESH commands ({cs,ras,cas,we} = 0001), each one cycle long. The first follows PRECHARGE ALL by max(t_rp,1)+1 cycles, and each later one follows its predecessor by max(t_rc,1)+1 cycles.
- R5: LOAD MODE REGISTER ({cs,ras,cas,we} = 0000) follows the last AUTO REFRESH by max(t_rc,1)+1 cycles. Bank address is 0 and the address bus is 0x030 (CAS latency 3 in bits 6:4, burst code 0 in bits 2:0).
- R6: `init_done_o` rises max(t_mrd,1)+1 cycles after LOAD MODE REGISTER and stays high until reset, with NOP driven.
- R7: Once `init_done_o` is high, `refresh_req_o` pulses for one cycle every P = t_refi−20 cycles (P = 1 when t_refi ≤ 21). The first pulse comes P−1 cycles after the first cycle of `init_done_o`.
- R8: A start pulse while the sequence runs or after it has finished has no effect on the commands issued or on `init_done_o`.
- R9: `twr_o` equals the largest of 12, t_ras−t_rcd and t_rc−t_rcd−t_rp, with a negative difference taken as 0. It is combinational from the inputs.
- R10: A wait input of 0 behaves as a wait of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin initialization (accepted in idle only) |
| t_pwr_i | input | 16 | Clock-stable wait, cycles |
| t_rp_i | input | 16 | Precharge period, cycles |
| t_rc_i | input | 16 | Row cycle / refresh period, cycles |
| t_mrd_i | input | 16 | Mode-register load period, cycles |
| t_ras_i | input | 16 | Row active time, cycles |
| t_rcd_i | input | 16 | Row-to-column delay, cycles |
| t_refi_i | input | 16 | Per-row refresh period, cycles |
| cke_o | output | 1 | Clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Address bus |
| init_done_o | output | 1 | Initialization complete |
| refresh_req_o | output | 1 | One-cycle refresh request |
| twr_o | output | 16 | Derived write-recovery time, cycles |

## Verification
The command pins and `cke_o` come straight from the state register. The bench therefore expects `cke_o` in the first cycle after the edge that samples start, and expects each later command at the cumulative offset max(t,1)+1 after the previous one. `init_done_o` is due max(t_mrd,1)+1 cycles after the mode load. The first `refresh_req_o` comes P−1 cycles after that, and later pulses every P cycles. `twr_o` is combinational and is read shortly after its inputs change. A monitor samples every falling edge and logs the cycle number of each non-NOP command, of the first `init_done_o` cycle and of each refresh pulse. The checks compare those logged cycle numbers with the offsets worked out from the inputs, so no check depends on polling at an edge.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PWR,
    ST_PRE,
    ST_PRE_W,
    ST_REF,
    ST_REF_W,
    ST_MRS,
    ST_MRS_W,
    ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          expire_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (len_i == '0) ? CW'(1) : len_i;
    end else if (cnt_q > CW'(1)) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expire_o = (cnt_q <= CW'(1));

  assert_zero_len_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && len_i == '0) |=> expire_o);

  assert_len_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && len_i > CW'(1)) |=> !expire_o);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int CW     = 16,
  parameter int MARGIN = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] t_refi_i,
  output logic          pulse_o
);

  localparam logic [CW-1:0] MARGIN_C = CW'(MARGIN);

  logic [CW-1:0] reload;
  logic [CW-1:0] cnt_q;

  assign reload = (t_refi_i > MARGIN_C + CW'(1)) ? (t_refi_i - MARGIN_C) : CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= reload;
    end else if (cnt_q <= CW'(1)) begin
      cnt_q <= reload;
    end else begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign pulse_o = en_i && (cnt_q <= CW'(1));

  assert_pulse_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && reload > CW'(1) && $stable(t_refi_i)) |=> !pulse_o);

  assert_no_pulse_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pulse_o);

endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int CAS_LAT = 3,
  parameter int BL_CODE = 0
) (
  input  cmd_e              cmd_i,
  output cmd_pins_t         pins_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int A10 = 10;
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'((CAS_LAT << 4) | BL_CODE);
  localparam logic [ADDR_W-1:0] PRE_ALL   = ADDR_W'(1) << A10;

  always_comb begin
    ba_o   = '0;
    addr_o = '0;
    unique case (cmd_i)
      CMD_DESEL: pins_o = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      CMD_PRE: begin
        pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
        addr_o = PRE_ALL;
      end
      CMD_REF:   pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS: begin
        pins_o = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
        addr_o = MODE_WORD;
      end
      default:   pins_o = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
  end

endmodule

// File: rtl/sdram_twr_calc.sv
module sdram_twr_calc #(
  parameter int CW      = 16,
  parameter int TWR_MIN = 12
) (
  input  logic [CW-1:0] t_ras_i,
  input  logic [CW-1:0] t_rcd_i,
  input  logic [CW-1:0] t_rc_i,
  input  logic [CW-1:0] t_rp_i,
  output logic [CW-1:0] twr_o
);

  logic [CW:0]   rcd_rp;
  logic [CW-1:0] term_a;
  logic [CW-1:0] term_b;
  logic [CW-1:0] ab_max;

  always_comb begin
    rcd_rp = {1'b0, t_rcd_i} + {1'b0, t_rp_i};
    term_a = (t_ras_i > t_rcd_i) ? (t_ras_i - t_rcd_i) : '0;
    term_b = ({1'b0, t_rc_i} > rcd_rp) ? CW'({1'b0, t_rc_i} - rcd_rp) : '0;
    ab_max = (term_a > term_b) ? term_a : term_b;
    twr_o  = (ab_max > CW'(TWR_MIN)) ? ab_max : CW'(TWR_MIN);
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CW      = 16,
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int NREF    = 8,
  parameter int CAS_LAT = 3,
  parameter int BL_CODE = 0,
  parameter int TWR_MIN = 12,
  parameter int MARGIN  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CW-1:0]     t_pwr_i,
  input  logic [CW-1:0]     t_rp_i,
  input  logic [CW-1:0]     t_rc_i,
  input  logic [CW-1:0]     t_mrd_i,
  input  logic [CW-1:0]     t_ras_i,
  input  logic [CW-1:0]     t_rcd_i,
  input  logic [CW-1:0]     t_refi_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o,
  output logic              refresh_req_o,
  output logic [CW-1:0]     twr_o
);

  localparam int RW = (NREF > 1) ? $clog2(NREF) : 1;
  localparam int SW = $clog2(NREF + 1);

  seq_state_e    state_q, state_d;
  logic [RW-1:0] ref_left_q, ref_left_d;
  logic          tmr_load;
  logic [CW-1:0] tmr_len;
  logic          tmr_expire;
  cmd_e          cmd;
  cmd_pins_t     pins;

  always_comb begin
    state_d    = state_q;
    ref_left_d = ref_left_q;
    tmr_load   = 1'b0;
    tmr_len    = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_PWR;
        tmr_load = 1'b1;
        tmr_len  = t_pwr_i;
      end
      ST_PWR:   if (tmr_expire) state_d = ST_PRE;
      ST_PRE: begin
        state_d  = ST_PRE_W;
        tmr_load = 1'b1;
        tmr_len  = t_rp_i;
      end
      ST_PRE_W: if (tmr_expire) begin
        state_d    = ST_REF;
        ref_left_d = RW'(NREF - 1);
      end
      ST_REF: begin
        state_d  = ST_REF_W;
        tmr_load = 1'b1;
        tmr_len  = t_rc_i;
      end
      ST_REF_W: if (tmr_expire) begin
        if (ref_left_q == '0) begin
          state_d = ST_MRS;
        end else begin
          state_d    = ST_REF;
          ref_left_d = ref_left_q - RW'(1);
        end
      end
      ST_MRS: begin
        state_d  = ST_MRS_W;
        tmr_load = 1'b1;
        tmr_len  = t_mrd_i;
      end
      ST_MRS_W: if (tmr_expire) state_d = ST_DONE;
      default:  state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ref_left_q <= '0;
    end else begin
      state_q    <= state_d;
      ref_left_q <= ref_left_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE: cmd = CMD_DESEL;
      ST_PRE:  cmd = CMD_PRE;
      ST_REF:  cmd = CMD_REF;
      ST_MRS:  cmd = CMD_MRS;
      default: cmd = CMD_NOP;
    endcase
  end

  sdram_wait_timer #(.CW(CW)) i_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .len_i    (tmr_len),
    .expire_o (tmr_expire)
  );

  sdram_cmd_enc #(
    .ADDR_W  (ADDR_W),
    .BA_W    (BA_W),
    .CAS_LAT (CAS_LAT),
    .BL_CODE (BL_CODE)
  ) i_enc (
    .cmd_i  (cmd),
    .pins_o (pins),
    .ba_o   (ba_o),
    .addr_o (addr_o)
  );

  sdram_refresh_timer #(.CW(CW), .MARGIN(MARGIN)) i_refresh (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (init_done_o),
    .t_refi_i (t_refi_i),
    .pulse_o  (refresh_req_o)
  );

  sdram_twr_calc #(.CW(CW), .TWR_MIN(TWR_MIN)) i_twr (
    .t_ras_i (t_ras_i),
    .t_rcd_i (t_rcd_i),
    .t_rc_i  (t_rc_i),
    .t_rp_i  (t_rp_i),
    .twr_o   (twr_o)
  );

  assign cke_o       = (state_q != ST_IDLE);
  assign cs_no       = pins.cs_n;
  assign ras_no      = pins.ras_n;
  assign cas_no      = pins.cas_n;
  assign we_no       = pins.we_n;
  assign init_done_o = (state_q == ST_DONE);

  // count of refreshes seen since leaving idle, for the sequence check
  logic [SW-1:0] ref_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ref_seen_q <= '0;
    else if (state_q == ST_IDLE) ref_seen_q <= '0;
    else if (state_q == ST_REF)  ref_seen_q <= ref_seen_q + SW'(1);
  end

  assert_ref_burst_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MRS) |-> (ref_seen_q == SW'(NREF)));

  assert_pre_a10_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRE) |-> (addr_o[10] && !cs_no && !ras_no && cas_no && !we_no));

  assert_done_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_PWR) |=> (state_q != ST_PWR && state_q != ST_IDLE));

  assert_twr_floor_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    twr_o >= CW'(TWR_MIN));

endmodule

// File: tb/test_sdram_init_seq.sv
`timescale 1ns/100ps
module test_sdram_init_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] t_pwr = 16'd5, t_rp = 16'd2, t_rc = 16'd6, t_mrd = 16'd2;
  logic [15:0] t_ras = 16'd5, t_rcd = 16'd3, t_refi = 16'd30;
  logic        cke, cs_n, ras_n, cas_n, we_n, done, rreq;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [15:0] twr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_init_seq i_sdram_init_seq (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .t_pwr_i (t_pwr), .t_rp_i (t_rp), .t_rc_i (t_rc), .t_mrd_i (t_mrd),
    .t_ras_i (t_ras), .t_rcd_i (t_rcd), .t_refi_i (t_refi),
    .cke_o (cke), .cs_no (cs_n), .ras_no (ras_n), .cas_no (cas_n), .we_no (we_n),
    .ba_o (ba), .addr_o (addr), .init_done_o (done), .refresh_req_o (rreq),
    .twr_o (twr)
  );

  // monitor: log cycles of commands, done rise and refresh pulses
  logic mon_clr = 1'b0;
  int   ev_cyc [32];
  int   ev_cmd [32];
  int   ev_addr[32];
  int   ev_ba  [32];
  int   n_ev = 0;
  int   rq_cyc [8];
  int   n_rq = 0;
  int   done_cyc = -1;
  int   cke_cyc = -1;
  logic prev_cke = 1'b0;

  always @(negedge clk) begin
    if (mon_clr) begin
      n_ev = 0; n_rq = 0; done_cyc = -1; cke_cyc = -1; prev_cke = cke;
    end else begin
      if (cke && !prev_cke) cke_cyc = cyc;
      prev_cke = cke;
      if (cke && {cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
        if (n_ev < 32) begin
          ev_cyc[n_ev]  = cyc;
          ev_cmd[n_ev]  = int'({cs_n, ras_n, cas_n, we_n});
          ev_addr[n_ev] = int'(addr);
          ev_ba[n_ev]   = int'(ba);
        end
        n_ev++;
      end
      if (done && done_cyc < 0) done_cyc = cyc;
      if (rreq) begin
        if (n_rq < 8) rq_cyc[n_rq] = cyc;
        n_rq++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int at_least1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  // ras, rcd, rc, rp, expected twr
  localparam int NV = 6;
  localparam int TWR_VEC [NV][5] = '{
    '{5,  3, 10,  2, 12},
    '{30, 10, 40, 10, 20},
    '{20, 5,  45, 10, 30},
    '{3,  8,  5,  9, 12},
    '{40, 2,  30, 3, 38},
    '{12, 0,  13, 0, 13}
  };

  task automatic run_seq(input int pwr, input int rp, input int rc, input int mrd,
                         input int refi, input bit poke);
    int a, c0, p, rpe, rce, mrde, per, base, total;
    t_pwr = 16'(pwr); t_rp = 16'(rp); t_rc = 16'(rc); t_mrd = 16'(mrd); t_refi = 16'(refi);
    mon_clr = 1'b1;
    step(1);
    mon_clr = 1'b0;
    a = cyc;
    start = 1'b1;
    step(1);
    start = 1'b0;
    c0   = a + 1;
    p    = at_least1(pwr);
    rpe  = at_least1(rp);
    rce  = at_least1(rc);
    mrde = at_least1(mrd);
    per  = (refi > 21) ? refi - 20 : 1;
    total = p + 1 + rpe + 8 * (rce + 1) + mrde + 1 + 3 * per + 4;
    if (poke) begin
      step(p + 2);
      start = 1'b1;           // R8: mid-sequence start
      step(1);
      start = 1'b0;
      step(total - p - 3);
    end else begin
      step(total);
    end
    check(cke_cyc == c0, "R2 cke rise", cke_cyc, c0);
    check(n_ev == 10, "R4 R8 command count", n_ev, 10);
    base = c0 + p;
    check(ev_cmd[0] == 2 && ev_cyc[0] == base, "R2 precharge cycle", ev_cyc[0], base);
    check(ev_addr[0] == 1024, "R3 precharge address", ev_addr[0], 1024);
    base = base + 1 + rpe;
    for (int k = 0; k < 8; k++) begin
      check(ev_cmd[1+k] == 1 && ev_cyc[1+k] == base + k * (rce + 1),
            "R4 auto refresh cycle", ev_cyc[1+k], base + k * (rce + 1));
    end
    base = base + 8 * (rce + 1);
    check(ev_cmd[9] == 0 && ev_cyc[9] == base, "R5 mode load cycle", ev_cyc[9], base);
    check(ev_addr[9] == 48 && ev_ba[9] == 0, "R5 mode word", ev_addr[9], 48);
    check(done_cyc == base + mrde + 1, "R6 init_done rise", done_cyc, base + mrde + 1);
    check(n_rq >= 3, "R7 refresh pulse count", n_rq, 3);
    check(rq_cyc[0] == done_cyc + per - 1, "R7 first refresh", rq_cyc[0], done_cyc + per - 1);
    check(rq_cyc[1] - rq_cyc[0] == per, "R7 refresh period", rq_cyc[1] - rq_cyc[0], per);
    check(rq_cyc[2] - rq_cyc[1] == per, "R7 refresh period", rq_cyc[2] - rq_cyc[1], per);
    // R8: start after completion
    start = 1'b1;
    step(1);
    start = 1'b0;
    step(3);
    check(done == 1'b1, "R8 done held after late start", int'(done), 1);
    check(n_ev == 10, "R8 no new commands", n_ev, 10);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    check(cke == 1'b0 && cs_n == 1'b1, "R1 reset pins", int'({cke, cs_n}), 1);
    check(done == 1'b0 && rreq == 1'b0, "R1 reset flags", int'({done, rreq}), 0);
    rst_n = 1'b1;
    step(2);
    check(cke == 1'b0 && cs_n == 1'b1 && done == 1'b0, "R1 idle before start",
          int'({cke, cs_n, done}), 2);

    // R9 vector table
    for (int i = 0; i < NV; i++) begin
      t_ras = 16'(TWR_VEC[i][0]); t_rcd = 16'(TWR_VEC[i][1]);
      t_rc  = 16'(TWR_VEC[i][2]); t_rp  = 16'(TWR_VEC[i][3]);
      #1;
      check(int'(twr) == TWR_VEC[i][4], "R9 twr", int'(twr), TWR_VEC[i][4]);
    end

    run_seq(5, 2, 6, 2, 30, 1'b0);

    // R1: reset from done
    rst_n = 1'b0;
    #1;
    check(cke == 1'b0 && cs_n == 1'b1 && done == 1'b0 && rreq == 1'b0,
          "R1 reset from done", int'({cke, cs_n, done, rreq}), 4);
    step(2);
    rst_n = 1'b1;
    step(2);

    // R10: zero waits, plus R8 mid-sequence start
    run_seq(0, 0, 0, 0, 25, 1'b1);

    // R1: reset mid-sequence
    rst_n = 1'b0;
    step(1);
    rst_n = 1'b1;
    step(1);
    t_pwr = 16'd20;
    start = 1'b1;
    step(1);
    start = 1'b0;
    step(5);
    rst_n = 1'b0;
    #1;
    check(cke == 1'b0 && cs_n == 1'b1 && done == 1'b0, "R1 reset mid sequence",
          int'({cke, cs_n, done}), 2);
    step(2);
    rst_n = 1'b1;
    step(1);

    run_seq(3, 4, 2, 5, 22, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule